// File: doc/BRIEF.md
# Piecewise-Linear Gamma Curve Evaluator

This block maps a 12-bit pixel component through a programmable transfer curve made of 64 straight-line pieces. The piece boundaries are fixed. They are narrow near black, where a gamma curve bends most, and wide near white. Each piece is described by one coefficient word. The word holds a fixed-point slope with 8 fractional bits and a 12-bit output value at the first code of the piece.

A configuration port writes coefficient words one at a time by piece index. A pixel stream with a valid flag enters the block, and the corrected code leaves two cycles later with its valid flag aligned. The package provides a helper function that builds a coefficient word from the curve outputs at a piece's first and last codes. Software models and testbenches can use it to fill the table. Coefficients are assumed to describe a non-decreasing curve. After reset the table holds the identity curve.

Top module: `gamma_pwl`

## Requirements
- R1: The input range 0..4095 is split into 64 pieces. Pieces 0..15 are one code wide and start at codes 0..15. Pieces 16..19 are 4 wide from 16, pieces 20..23 are 8 wide from 32, pieces 24..27 are 16 wide from 64, and pieces 28..31 are 32 wide from 128. Pieces 32..35 are 64 wide from 256, and pieces 36..63 are 128 wide from 512.
- R2: In a coefficient word, bits 27:16 are the unsigned slope (8 fractional bits) and bits 11:0 are the base output. Bits 31:28 and 15:12 are ignored.
- R3: For an input code x in piece i with first code s, the output is base_i + ((x − s) × slope_i) >> 8.
- R4: When that sum exceeds 4095, the output is 4095.
- R5: A pixel in a one-code piece produces the piece's base value whatever slope is stored.
- R6: The output valid flag equals the input valid flag two cycles earlier. Each valid output corresponds to the input code sampled two cycles earlier. During reset the output valid is 0 and the output code is 0.
- R7: A coefficient write affects pixels presented in later cycles. A pixel presented in the same cycle as the write still uses the old word.
- R8: After reset, every piece of width greater than 1 holds slope 256 with base equal to its first code. One-code pieces hold slope 0 with base equal to their code. As a result, every input maps to itself.
- R9: The helper `coef_pack(s_out, e_out, seg)` returns the base s_out in bits 11:0. It places the slope in bits 27:16, computed as ((e_out − s_out) × 256) / (width − 1) and kept to its low 12 bits. The slope is 0 for one-code pieces.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Coefficient write strobe |
| cfg_idx_i | input | 6 | Piece index to write |
| cfg_wdata_i | input | 32 | Coefficient word |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_i | input | 12 | Input pixel code |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_o | output | 12 | Corrected pixel code |

## Verification
Two situations are hard to reach from the ports. One is saturation, which the identity table never produces. The other is a write colliding with a pixel that lands in the very piece being rewritten. The stimulus loads a steep word with a high base into the last piece and drives its last code to force clamping. It then writes one piece and, in the same cycle, presents a pixel that falls inside it, followed by the same pixel on the next cycle. Both the old and the new word must appear at the output, one after the other.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
  localparam int PIX_W  = 12;
  localparam int NSEG   = 64;
  localparam int SEG_W  = $clog2(NSEG);
  localparam int COEF_W = 12;
  localparam int FRAC_W = 8;
  localparam int OFS_W  = 7;   // log2 of widest piece
  localparam int ENT_W  = 2 * COEF_W;
  localparam int PIX_MAX = (1 << PIX_W) - 1;

  function automatic int seg_lg(int i);
    if (i < 16) return 0;
    if (i < 36) return 2 + (i - 16) / 4;
    return 7;
  endfunction

  function automatic int seg_start(int i);
    if (i < 16) return i;
    if (i < 36) return (16 << ((i - 16) / 4)) + ((i - 16) % 4) * (4 << ((i - 16) / 4));
    return 512 + (i - 36) * 128;
  endfunction

  function automatic logic [31:0] coef_pack(int s_out, int e_out, int seg);
    int w;
    int slope;
    w = 1 << seg_lg(seg);
    slope = (w == 1) ? 0 : ((e_out - s_out) * 256) / (w - 1);
    return {4'b0, 12'(slope), 4'b0, 12'(s_out)};
  endfunction

  function automatic logic [ENT_W-1:0] ident_ent(int i);
    int slope;
    slope = (seg_lg(i) == 0) ? 0 : (1 << FRAC_W);
    return {COEF_W'(slope), COEF_W'(seg_start(i))};
  endfunction
endpackage

// File: rtl/gamma_seg_dec.sv
module gamma_seg_dec
  import gamma_pkg::*;
(
  input  logic [PIX_W-1:0] code_i,
  output logic [SEG_W-1:0] seg_o,
  output logic [OFS_W-1:0] ofs_o
);
  logic [PIX_W-1:0] base;

  // priority on leading one: later (higher) levels override earlier ones
  always_comb begin
    seg_o = SEG_W'(code_i[3:0]);
    base  = code_i;
    for (int p = 4; p <= 8; p++) begin
      if ((code_i >> p) == PIX_W'(1)) begin
        seg_o = SEG_W'(16 + 4 * (p - 4)) + SEG_W'((code_i >> (p - 2)) & PIX_W'(3));
        base  = code_i & ~((PIX_W'(1) << (p - 2)) - PIX_W'(1));
      end
    end
    if (code_i[11:9] != 3'd0) begin
      seg_o = SEG_W'(32) + SEG_W'(code_i[11:7]);
      base  = {code_i[11:7], 7'd0};
    end
    ofs_o = OFS_W'(code_i - base);
  end
endmodule

// File: rtl/gamma_coef_tab.sv
module gamma_coef_tab
  import gamma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SEG_W-1:0]  widx_i,
  input  logic [31:0]       wdata_i,
  input  logic [SEG_W-1:0]  ridx_i,
  output logic [COEF_W-1:0] slope_o,
  output logic [COEF_W-1:0] base_o
);
  logic [ENT_W-1:0] tab_q [NSEG];
  logic unused_bits;
  assign unused_bits = ^{wdata_i[31:28], wdata_i[15:12]};

  for (genvar g = 0; g < NSEG; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           tab_q[g] <= ident_ent(g);
      else if (we_i && widx_i == SEG_W'(g)) tab_q[g] <= {wdata_i[27:16], wdata_i[11:0]};
    end
  end

  assign {slope_o, base_o} = tab_q[ridx_i];

  assert_wr_fields_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> tab_q[$past(widx_i)] == {$past(wdata_i[27:16]), $past(wdata_i[11:0])});
endmodule

// File: rtl/gamma_interp.sv
module gamma_interp
  import gamma_pkg::*;
(
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [COEF_W-1:0] slope_i,
  input  logic [COEF_W-1:0] base_i,
  output logic [PIX_W-1:0]  val_o
);
  localparam int PROD_W = OFS_W + COEF_W;
  localparam int SUM_W  = PROD_W + 1;

  logic [PROD_W-1:0] prod;
  logic [SUM_W-1:0]  sum;

  always_comb begin
    prod  = PROD_W'(ofs_i) * PROD_W'(slope_i);
    sum   = SUM_W'(base_i) + SUM_W'(prod >> FRAC_W);
    val_o = (sum > SUM_W'(PIX_MAX)) ? PIX_W'(PIX_MAX) : sum[PIX_W-1:0];
  end
endmodule

// File: rtl/gamma_pwl.sv
module gamma_pwl
  import gamma_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [5:0]       cfg_idx_i,
  input  logic [31:0]      cfg_wdata_i,
  input  logic             pix_valid_i,
  input  logic [11:0]      pix_i,
  output logic             pix_valid_o,
  output logic [11:0]      pix_o
);
  logic [SEG_W-1:0]  seg;
  logic [OFS_W-1:0]  ofs;
  logic [COEF_W-1:0] rd_slope, rd_base;
  logic              s1_v;
  logic [OFS_W-1:0]  s1_ofs;
  logic [COEF_W-1:0] s1_slope, s1_base;
  logic [PIX_W-1:0]  res;

  gamma_seg_dec u_dec (.code_i(pix_i), .seg_o(seg), .ofs_o(ofs));

  gamma_coef_tab u_tab (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .widx_i(cfg_idx_i), .wdata_i(cfg_wdata_i),
    .ridx_i(seg), .slope_o(rd_slope), .base_o(rd_base)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v <= 1'b0; s1_ofs <= '0; s1_slope <= '0; s1_base <= '0;
    end else begin
      s1_v <= pix_valid_i; s1_ofs <= ofs; s1_slope <= rd_slope; s1_base <= rd_base;
    end
  end

  gamma_interp u_int (.ofs_i(s1_ofs), .slope_i(s1_slope), .base_i(s1_base), .val_o(res));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_valid_o <= 1'b0; pix_o <= '0;
    end else begin
      pix_valid_o <= s1_v; pix_o <= res;
    end
  end

  logic [1:0] since_rst;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               since_rst <= '0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  assert_seg_cover_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_start(int'(seg)) + int'(ofs) == int'(pix_i)) && (int'(ofs) < (1 << seg_lg(int'(seg)))));
  assert_valid_lat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd2) |-> pix_valid_o == $past(pix_valid_i, 2));
  assert_out_floor_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd2) |-> pix_o >= $past(s1_base));
  assert_flat_piece_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_ofs == '0) |=> pix_o == $past(s1_base));
endmodule

// File: tb/tb_gamma_pwl.sv
`timescale 1ns/1ps
module tb_gamma_pwl;
  import gamma_pkg::coef_pack;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_ni = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        pv_i = 1'b0;
  logic [11:0] px_i = '0;
  logic        pv_o;
  logic [11:0] px_o;

  gamma_pwl dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx),
    .cfg_wdata_i(cfg_wdata), .pix_valid_i(pv_i), .pix_i(px_i),
    .pix_valid_o(pv_o), .pix_o(px_o)
  );

  int b_start[64], b_w[64], r_slope[64], r_base[64];
  int hv[2], hd[2];
  string ht[2];
  int n_chk = 0, n_fail = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int find_seg(int x);
    for (int i = 0; i < 64; i++)
      if (x >= b_start[i] && x < b_start[i] + b_w[i]) return i;
    return -1;
  endfunction

  function automatic int model(int x);
    int i, v;
    i = find_seg(x);
    v = r_base[i] + (((x - b_start[i]) * r_slope[i]) >> 8);
    return (v > 4095) ? 4095 : v;
  endfunction

  function automatic int curve(int x);
    return (x * x) >> 12;
  endfunction

  task automatic step(bit v, int x, bit we, int idx, logic [31:0] wd, string tag);
    @(negedge clk);
    chk("R6 valid", int'(pv_o), hv[1]);
    if (hv[1] != 0) chk(ht[1], int'(px_o), hd[1]);
    pv_i = v; px_i = 12'(x); cfg_we = we; cfg_idx = 6'(idx); cfg_wdata = wd;
    hv[1] = hv[0]; hd[1] = hd[0]; ht[1] = ht[0];
    hv[0] = v; hd[0] = v ? model(x) : 0; ht[0] = tag;
    if (we) begin
      r_slope[idx] = int'(wd[27:16]);
      r_base[idx]  = int'(wd[11:0]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R6 actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int acc, k, sg;
    acc = 0; k = 0;
    for (int i = 0; i < 16; i++) begin b_start[k] = acc; b_w[k] = 1; acc += 1; k++; end
    for (int g = 0; g < 5; g++)
      for (int j = 0; j < 4; j++) begin b_start[k] = acc; b_w[k] = 4 << g; acc += 4 << g; k++; end
    while (k < 64) begin b_start[k] = acc; b_w[k] = 128; acc += 128; k++; end
    // R8 identity contents
    for (int i = 0; i < 64; i++) begin
      r_base[i] = b_start[i];
      r_slope[i] = (b_w[i] > 1) ? 256 : 0;
    end
    for (int i = 0; i < 2; i++) begin hv[i] = 0; hd[i] = 0; ht[i] = "none"; end

    repeat (3) @(negedge clk);
    chk("R6 reset valid", int'(pv_o), 0);
    chk("R6 reset data", int'(px_o), 0);
    rst_ni = 1'b1;

    for (int x = 0; x < 4096; x++) step(1, x, 0, 0, 0, "R8 identity");

    chk("R9 pack wide", int'(coef_pack(100, 228, 63)), 32'h0102_0064);
    chk("R9 pack one-code", int'(coef_pack(5, 5, 5)), 32'h0000_0005);
    chk("R9 pack wrap", int'(coef_pack(0, 4095, 40)), 32'h003E_0000);

    for (int i = 0; i < 64; i++)
      step(0, 0, 1, i, coef_pack(curve(b_start[i]), curve(b_start[i] + b_w[i] - 1), i), "R7 program");
    for (int i = 0; i < 64; i++) begin
      step(1, b_start[i], 0, 0, 0, "R1 first code");
      step(1, b_start[i] + b_w[i] - 1, 0, 0, 0, "R1 last code");
    end
    for (int n = 0; n < 3000; n++)
      step(($urandom % 4) != 0, int'($urandom % 4096), 0, 0, 0, "R3 random");

    step(0, 0, 1, 5, 32'hAFFF_504D, "R2 write");
    step(1, 5, 0, 0, 0, "R5 one-code piece");
    step(0, 0, 1, 40, 32'h5123_F456, "R2 write");
    step(1, 1124, 0, 0, 0, "R2 field decode");
    step(1, 1151, 0, 0, 0, "R2 field decode");

    step(0, 0, 1, 63, 32'h0FFF_0FA0, "R4 write");
    step(1, 4095, 0, 0, 0, "R4 saturate");
    step(1, 4000, 0, 0, 0, "R4 saturate");
    step(1, 3968, 0, 0, 0, "R4 piece start");

    sg = find_seg(2000);
    step(1, 2000, 1, sg, 32'h0000_0123, "R7 same-cycle old");
    step(1, 2000, 0, 0, 0, "R7 next-cycle new");
    step(0, 0, 0, 0, 0, "R6 idle");

    repeat (3) step(0, 0, 0, 0, 0, "R6 flush");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule